// File: doc/BRIEF.md
# Dual-Address I2C Slave Address Matcher

This block decides the slave's reply in the acknowledge slot that follows an I2C address byte. When the shifter has collected the eight address-phase bits, it raises a one-cycle completion strobe. On that strobe the matcher compares the upper seven bits against two programmable own addresses.

The first own address is always live. The second one takes part only while its enable input is high. A match on either live address produces an acknowledge. A miss leaves SDA released, so the bus master sees a NAK.

The matcher also captures the direction bit, which is bit 0 of the byte. It raises a status flag when the address it acknowledged was the second one. All results are registered on the strobe and held until the next address phase. Byte shifting and the data phases belong to neighbouring logic.

Top module: `i2c_dual_addr_match`

## Requirements
- R1: After reset, ack_o, match_o, rw_o and alt_match_o are all 0.
- R2: With sec_en_i low, the cycle after an addr_done_i strobe has ack_o = 1 exactly when addr_byte_i[7:1] equals own_addr_pri_i.
- R3: With sec_en_i high, the cycle after a strobe has ack_o = 1 when addr_byte_i[7:1] equals own_addr_pri_i or own_addr_sec_i.
- R4: The primary address is compared for every strobe, whatever the level of sec_en_i.
- R5: alt_match_o is 1 after a strobe only when the secondary address is enabled and matched and the primary address did not match.
- R6: When both addresses equal the received address, the primary wins: ack_o = 1 and alt_match_o = 0.
- R7: rw_o takes the value of addr_byte_i[0] at each strobe (1 = read, 0 = write).
- R8: Between strobes, ack_o, rw_o and alt_match_o hold their values whatever the other inputs do.
- R9: match_o is a single-cycle pulse in the cycle after a strobe that produced an acknowledge, and is 0 otherwise.
- R10: On no match, ack_o = 0 (SDA released, NAK) and alt_match_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_byte_i | input | 8 | Received address byte: [7:1] address, [0] direction |
| addr_done_i | input | 1 | One-cycle strobe: address byte complete |
| own_addr_pri_i | input | 7 | Primary own address, always active |
| own_addr_sec_i | input | 7 | Secondary own address |
| sec_en_i | input | 1 | Enable for the secondary address |
| ack_o | output | 1 | 1 = pull SDA low in the acknowledge slot |
| match_o | output | 1 | One-cycle pulse on an acknowledged address |
| rw_o | output | 1 | Latched direction bit |
| alt_match_o | output | 1 | Acknowledged address was the secondary one |

## Verification
The two comparisons can succeed on the same strobe, and the priority between them then sets the status flag. This case is provoked by programming both own addresses to the same value while the secondary enable is high, and by sweeping every address byte through it. It is judged correct when ack_o is high and alt_match_o stays clear on the single matching byte pair. A second configuration with distinct addresses shows that the flag does rise when only the secondary address matches.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int AM_ADDR_W = 7;

  typedef struct packed {
    logic ack;
    logic alt;
    logic rw;
  } am_result_t;
endpackage

// File: rtl/am_addr_cmp.sv
module am_addr_cmp #(
  parameter int ADDR_W = 7,
  parameter int NUM_SLOTS = 2
) (
  input  logic [ADDR_W-1:0]                rx_addr_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] own_addr_i,
  input  logic [NUM_SLOTS-1:0]             slot_en_i,
  output logic [NUM_SLOTS-1:0]             hit_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign hit_o[g] = slot_en_i[g] && (rx_addr_i == own_addr_i[g]);
  end
endmodule

// File: rtl/am_prio_sel.sv
module am_prio_sel #(
  parameter int NUM_SLOTS = 2,
  localparam int IdxW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] hit_i,
  output logic                 any_o,
  output logic [IdxW-1:0]      sel_o,
  output logic                 alt_o
);
  // slot 0 has highest priority: scan downward so lowest index wins
  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        sel_o = i[IdxW-1:0];
      end
    end
    alt_o = any_o && (sel_o != '0);
  end
endmodule

// File: rtl/am_status_reg.sv
module am_status_reg
  import i2c_am_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  am_result_t next_i,
  output am_result_t cur_o,
  output logic       pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= load_i && next_i.ack;
      if (load_i) cur_o <= next_i;
    end
  end
endmodule

// File: rtl/i2c_dual_addr_match.sv
module i2c_dual_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = AM_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W:0]   addr_byte_i,
  input  logic              addr_done_i,
  input  logic [ADDR_W-1:0] own_addr_pri_i,
  input  logic [ADDR_W-1:0] own_addr_sec_i,
  input  logic              sec_en_i,
  output logic              ack_o,
  output logic              match_o,
  output logic              rw_o,
  output logic              alt_match_o
);
  localparam int NumSlots = 2;
  localparam int IdxW     = $clog2(NumSlots);

  logic [NumSlots-1:0][ADDR_W-1:0] own_addrs;
  logic [NumSlots-1:0]             slot_en;
  logic [NumSlots-1:0]             hit;
  logic                            any_hit;
  logic [IdxW-1:0]                 sel;
  logic                            alt_hit;
  am_result_t                      nxt, cur;

  assign own_addrs[0] = own_addr_pri_i;
  assign own_addrs[1] = own_addr_sec_i;
  assign slot_en      = {sec_en_i, 1'b1};  // primary has no disable

  am_addr_cmp #(.ADDR_W(ADDR_W), .NUM_SLOTS(NumSlots)) i_cmp (
    .rx_addr_i (addr_byte_i[ADDR_W:1]),
    .own_addr_i(own_addrs),
    .slot_en_i (slot_en),
    .hit_o     (hit)
  );

  am_prio_sel #(.NUM_SLOTS(NumSlots)) i_prio (
    .hit_i(hit),
    .any_o(any_hit),
    .sel_o(sel),
    .alt_o(alt_hit)
  );

  assign nxt.ack = any_hit;
  assign nxt.alt = alt_hit;
  assign nxt.rw  = addr_byte_i[0];

  am_status_reg i_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (addr_done_i),
    .next_i (nxt),
    .cur_o  (cur),
    .pulse_o(match_o)
  );

  assign ack_o       = cur.ack;
  assign alt_match_o = cur.alt;
  assign rw_o        = cur.rw;
endmodule

// File: rtl/i2c_dual_addr_match_chk.sv
module i2c_dual_addr_match_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W:0]   addr_byte_i,
  input logic              addr_done_i,
  input logic [ADDR_W-1:0] own_addr_pri_i,
  input logic [ADDR_W-1:0] own_addr_sec_i,
  input logic              sec_en_i,
  input logic              ack_o,
  input logic              match_o,
  input logic              rw_o,
  input logic              alt_match_o
);
  logic pri_eq, sec_eq;
  assign pri_eq = addr_byte_i[ADDR_W:1] == own_addr_pri_i;
  assign sec_eq = sec_en_i && (addr_byte_i[ADDR_W:1] == own_addr_sec_i);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !ack_o && !match_o && !rw_o && !alt_match_o);

  assert_pri_always_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_i && pri_eq |=> ack_o);

  assert_sec_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_i && !sec_en_i |=> !alt_match_o);

  assert_sec_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_i && sec_eq && !pri_eq |=> ack_o && alt_match_o);

  assert_pri_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_i && pri_eq |=> !alt_match_o);

  assert_alt_needs_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_match_o |-> ack_o);

  assert_rw_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_i |=> rw_o == $past(addr_byte_i[0]));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_done_i |=> $stable(ack_o) && $stable(rw_o) && $stable(alt_match_o));

  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ack_o && $past(addr_done_i));

  assert_nak_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_i && !pri_eq && !sec_eq |=> !ack_o && !match_o && !alt_match_o);
endmodule

bind i2c_dual_addr_match i2c_dual_addr_match_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_i2c_dual_addr_match.sv
module test_i2c_dual_addr_match;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_byte_i = '0;
  logic       addr_done_i = 1'b0;
  logic [6:0] own_addr_pri_i = '0;
  logic [6:0] own_addr_sec_i = '0;
  logic       sec_en_i = 1'b0;
  logic       ack_o, match_o, rw_o, alt_match_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  i2c_dual_addr_match i_i2c_dual_addr_match (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // drive strobe at negedge, sample at next negedge (one register stage)
  task automatic do_addr(input logic [7:0] b, input logic [6:0] p,
                         input logic [6:0] s, input logic en);
    logic pe, se, e_ack, e_alt;
    pe    = (b[7:1] == p);
    se    = en && (b[7:1] == s);
    e_ack = pe || se;
    e_alt = se && !pe;
    addr_byte_i = b; own_addr_pri_i = p; own_addr_sec_i = s; sec_en_i = en;
    addr_done_i = 1'b1;
    @(negedge clk_i);
    addr_done_i = 1'b0;
    if (pe && se)      chk("R6", ack_o, 1'b1);
    else if (!e_ack)   chk("R10", ack_o, 1'b0);
    else if (!en)      chk("R2", ack_o, e_ack);
    else               chk("R3", ack_o, e_ack);
    if (pe) chk("R4", ack_o, 1'b1);
    chk("R5", alt_match_o, e_alt);
    chk("R7", rw_o, b[0]);
    chk("R9", match_o, e_ack);
    @(negedge clk_i);
    chk("R9", match_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] pri_set [3] = '{7'h2A, 7'h3C, 7'h7F};
    logic [6:0] sec_set [3] = '{7'h55, 7'h3C, 7'h00};
    repeat (3) @(negedge clk_i);
    chk("R1", ack_o, 1'b0);
    chk("R1", match_o, 1'b0);
    chk("R1", rw_o, 1'b0);
    chk("R1", alt_match_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int c = 0; c < 3; c++)
      for (int en = 0; en < 2; en++)
        for (int b = 0; b < 256; b++)
          do_addr(b[7:0], pri_set[c], sec_set[c], en[0]);

    // R8: secondary hit then scramble inputs without strobe
    do_addr({7'h55, 1'b1}, 7'h2A, 7'h55, 1'b1);
    addr_byte_i = 8'h00; own_addr_pri_i = 7'h11; own_addr_sec_i = 7'h22; sec_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R8", ack_o, 1'b1);
    chk("R8", alt_match_o, 1'b1);
    chk("R8", rw_o, 1'b1);
    // and after a NAK, matching inputs without strobe must not acknowledge
    do_addr(8'h00, 7'h11, 7'h22, 1'b0);
    addr_byte_i = {7'h11, 1'b1}; sec_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8", ack_o, 1'b0);
    chk("R8", rw_o, 1'b0);
    chk("R8", match_o, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule